// File: doc/BRIEF.md
# 8-bit PWM Timer with Delayed Duty Transfer

This block is an 8-bit up-counter that turns two compare values into a pulse-width modulated output. A period value decides when the counter wraps to zero. A duty value decides how long the output stays high after each wrap. A mode register holds a run bit and a 3-bit field that picks the count clock from a power-of-two divider of the system clock. A small register port writes and reads the settings. The block drives a PWM output, a one-cycle pulse on each period match, and a flag that marks a restart made without a fresh duty value.

Protection rules are enforced in hardware. While the timer runs, the period value and the clock-select field cannot be written. A duty value written while running goes into a holding register first. It reaches the active comparator only on the third count-clock tick after the write. After every stop, the duty register has to be written again before the next start; if it is not, the output stays low for every cycle until a duty value has been written and transferred.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the PWM output, the match pulse and the stale flag are 0. The mode register reads 00h, the period register reads FFh and the duty register reads 00h.
- R2: Register addresses: 0 is mode (bit 7 run, bits 2:0 clock select, other bits read 0), 1 is period (N), 2 is duty (M), 3 reads 00h. While stopped, writes to any of them take effect and read back.
- R3: While running with valid M < N, the counter runs through 0..N on count ticks and then clears. The output rises at each clear (and at start) and falls on the tick where the counter equals M. The output is therefore high for M+1 ticks out of every N+1 ticks.
- R4: On the tick where the counter equals N, the match pulse is high for exactly one clock cycle, once per period.
- R5: With clock-select value k, one count tick occurs every 2^k clock cycles while running. Period and high time in clock cycles scale by 2^k.
- R6: While running, writes to the period register are ignored.
- R7: While running, a mode write changes only the run bit; the clock-select field keeps its value.
- R8: A duty write while running updates the duty register at once. The active comparator takes the new value on the third count tick after the write, so the compare on that tick and earlier ticks still uses the old value.
- R9: A start (run bit 0 to 1) with no duty write since the last stop (or since reset) sets the stale flag. The output then stays low for whole periods until a later duty write has been transferred, and that transfer clears the flag. A duty rewrite before the start, even with an unchanged value, avoids the stale state.
- R10: Clearing the run bit returns the counter to 0 and forces the output low. No match pulse occurs while stopped.
- R11: The edge settings N=FFh, M=FEh and N=01h, M=00h give periods of 256 and 2 ticks, with high times of 255 and 1 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pwm_o | output | 1 | PWM waveform |
| irq_o | output | 1 | One-cycle pulse on each period match |
| stale_o | output | 1 | Set while running after a restart without a duty rewrite |

## Verification
The waveform is measured as cycles between match pulses and high cycles within each period. This is done for a mid-range setting, for two edge settings (N=FFh with M=FEh, and N=01h with M=00h), and with a divided count clock. These runs separate errors in the wrap point, the fall point and tick scaling. A duty change is placed on the cycle right after a wrap, lowering M from 3 to 2. With this placement, a transfer one or two ticks early shows a different high time than the correct third-tick transfer. Restarts are tried both with and without a duty rewrite, and with an unchanged value. Register writes made while running are read back to show that they were ignored.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADR_MODE   = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_PERIOD = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_DUTY   = 2'd2;
endpackage

// File: rtl/pwm8_prescaler.sv
// Count-tick generator: a divider that is held at zero while stopped.
module pwm8_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_state_t;

    pre_state_t       st_d, st_q;
    logic [DIV_W-1:0] mask;

    // mask holds the low sel bits of the divider
    for (genvar g = 0; g < DIV_W; g++) begin : g_mask
        assign mask[g] = (sel > SEL_W'(g));
    end

    always_comb begin
        st_d = st_q;
        if (run) st_d.div = st_q.div + 1'b1;
        else     st_d.div = '0;
        tick = run && ((st_q.div & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm8_duty_shadow.sv
// Duty holding register, delayed transfer to the active comparator,
// and restart rewrite tracking.
module pwm8_duty_shadow #(
    parameter int DATA_W     = 8,
    parameter int XFER_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              start,
    input  logic              stop,
    input  logic              tick,
    input  logic              wr_duty,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] duty_reg,
    output logic [DATA_W-1:0] duty_act,
    output logic              stale_q_o,
    output logic              stale_nx
);
    localparam int XCNT_W = (XFER_TICKS > 1) ? $clog2(XFER_TICKS) : 1;
    localparam logic [XCNT_W-1:0] XLAST = XCNT_W'(XFER_TICKS - 1);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] act;
        logic [XCNT_W-1:0] xcnt;
        logic              pend;
        logic              dirty;
        logic              stale;
    } shd_state_t;

    shd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_duty) begin
            st_d.hold = wdata;
            if (run) begin
                st_d.pend = 1'b1;
                st_d.xcnt = '0;
            end else begin
                st_d.dirty = 1'b1;
            end
        end else if (run && st_q.pend && tick) begin
            if (st_q.xcnt == XLAST) begin
                st_d.act   = st_q.hold;
                st_d.pend  = 1'b0;
                st_d.stale = 1'b0;
            end else begin
                st_d.xcnt = st_q.xcnt + 1'b1;
            end
        end
        if (start) begin
            if (st_q.dirty) begin
                st_d.act   = st_q.hold;
                st_d.stale = 1'b0;
            end else begin
                st_d.stale = 1'b1;
            end
            st_d.dirty = 1'b0;
            st_d.pend  = 1'b0;
        end
        if (stop) begin
            st_d.dirty = 1'b0;
            st_d.pend  = 1'b0;
            st_d.stale = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign duty_reg  = st_q.hold;
    assign duty_act  = st_q.act;
    assign stale_q_o = st_q.stale;
    assign stale_nx  = st_d.stale;
endmodule

// File: rtl/pwm8_core.sv
// Counter, period match, PWM level and match pulse.
module pwm8_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              start,
    input  logic              stop,
    input  logic              tick,
    input  logic [DATA_W-1:0] period,
    input  logic [DATA_W-1:0] duty_act,
    input  logic              stale_nx,
    output logic              pwm_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic              pwm;
        logic              irq;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (stop) begin
            st_d.cnt = '0;
            st_d.pwm = 1'b0;
        end else if (start) begin
            st_d.cnt = '0;
            st_d.pwm = !stale_nx;
        end else if (run && tick) begin
            if (st_q.cnt == period) begin
                st_d.cnt = '0;
                st_d.pwm = !stale_nx;
                st_d.irq = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == duty_act) st_d.pwm = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = st_q.pwm;
    assign irq_o = st_q.irq;
endmodule

// File: rtl/pwm_timer8.sv
// Top: register port, write protection, and the three units.
module pwm_timer8 #(
    parameter int DATA_W     = 8,
    parameter int SEL_W      = 3,
    parameter int XFER_TICKS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [pwm8_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        pwm_o,
    output logic                        irq_o,
    output logic                        stale_o
);
    import pwm8_pkg::*;

    localparam int RUN_BIT = DATA_W - 1;

    typedef struct packed {
        logic              en;
        logic [SEL_W-1:0]  cs;
        logic [DATA_W-1:0] per;
    } regs_t;

    regs_t             regs_d, regs_q;
    logic              wr_mode, wr_per, wr_duty;
    logic              start, stop, run, tick;
    logic [SEL_W-1:0]  cs;
    logic [DATA_W-1:0] per, duty_reg, duty_act;
    logic              stale_nx;

    always_comb begin
        wr_mode = bus_wr && (bus_addr == ADR_MODE);
        wr_per  = bus_wr && (bus_addr == ADR_PERIOD);
        wr_duty = bus_wr && (bus_addr == ADR_DUTY);
        start   = wr_mode && bus_wdata[RUN_BIT] && !regs_q.en;
        stop    = wr_mode && !bus_wdata[RUN_BIT] && regs_q.en;

        regs_d = regs_q;
        if (wr_mode) begin
            regs_d.en = bus_wdata[RUN_BIT];
            if (!regs_q.en) regs_d.cs = bus_wdata[SEL_W-1:0];
        end
        if (wr_per && !regs_q.en) regs_d.per = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.en  <= 1'b0;
            regs_q.cs  <= '0;
            regs_q.per <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign run = regs_q.en;
    assign cs  = regs_q.cs;
    assign per = regs_q.per;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_MODE: begin
                bus_rdata[RUN_BIT]   = regs_q.en;
                bus_rdata[SEL_W-1:0] = regs_q.cs;
            end
            ADR_PERIOD: bus_rdata = regs_q.per;
            ADR_DUTY:   bus_rdata = duty_reg;
            default:    bus_rdata = '0;
        endcase
    end

    pwm8_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(cs), .tick(tick)
    );

    pwm8_duty_shadow #(.DATA_W(DATA_W), .XFER_TICKS(XFER_TICKS)) u_shd (
        .clk(clk), .rst_n(rst_n), .run(run), .start(start), .stop(stop),
        .tick(tick), .wr_duty(wr_duty), .wdata(bus_wdata),
        .duty_reg(duty_reg), .duty_act(duty_act),
        .stale_q_o(stale_o), .stale_nx(stale_nx)
    );

    pwm8_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(run), .start(start), .stop(stop),
        .tick(tick), .period(per), .duty_act(duty_act), .stale_nx(stale_nx),
        .pwm_o(pwm_o), .irq_o(irq_o)
    );
endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              tick,
    input logic [SEL_W-1:0]  cs,
    input logic [DATA_W-1:0] per,
    input logic [DATA_W-1:0] duty_act,
    input logic              pwm,
    input logic              irq,
    input logic              stale
);
    assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!pwm && !irq));

    assert_period_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (per == $past(per)));

    assert_sel_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (cs == $past(cs)));

    assert_stale_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stale |-> !pwm);

    assert_xfer_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (duty_act != $past(duty_act))) |-> $past(tick));

    assert_wrap_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pwm || stale));
endmodule

bind pwm_timer8 pwm_timer8_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cs(cs), .per(per),
    .duty_act(duty_act), .pwm(pwm_o), .irq(irq_o), .stale(stale_o)
);

// File: tb/pwm_timer8_tb.sv
`timescale 1ns/1ps
module pwm_timer8_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       pwm_o, irq_o, stale_o;

    always #2.5 clk = ~clk;

    pwm_timer8 u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_o(pwm_o), .irq_o(irq_o), .stale_o(stale_o)
    );

    typedef struct {
        int    per;
        int    hi;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    int   n_checks = 0;
    int   n_fail = 0;
    int   per_acc = 0;
    int   hi_acc = 0;
    bit   seen = 1'b0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Monitor: measures each period between match pulses, compares with queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_o) begin
                if (seen && exp_q.size() > 0) begin
                    cur = exp_q.pop_front();
                    check(per_acc == cur.per, {cur.tag, " period cycles"}, per_acc, cur.per);
                    check(hi_acc == cur.hi, {cur.tag, " high cycles"}, hi_acc, cur.hi);
                end
                per_acc = 1;
                hi_acc  = pwm_o ? 1 : 0;
                seen    = 1'b1;
            end else begin
                per_acc = per_acc + 1;
                hi_acc  = hi_acc + (pwm_o ? 1 : 0);
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic read_check(input logic [1:0] a, input int expv, input string what);
        bus_addr = a;
        #1;
        check(bus_rdata == 8'(expv), what, int'(bus_rdata), expv);
    endtask

    task automatic wait_irq();
        do begin
            @(negedge clk); #1;
        end while (!irq_o);
    endtask

    task automatic push(input int p, input int h, input string tag);
        exp_t e;
        e.per = p; e.hi = h; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Driver: settle two periods, then expect n identical periods
    task automatic expect_run(input int p, input int h, input int n, input string tag);
        wait_irq();
        wait_irq();
        for (int i = 0; i < n; i++) push(p, h, tag);
        drain();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 reset state
        check(pwm_o == 1'b0, "R1 pwm after reset", int'(pwm_o), 0);
        check(irq_o == 1'b0, "R1 irq after reset", int'(irq_o), 0);
        check(stale_o == 1'b0, "R1 stale after reset", int'(stale_o), 0);
        read_check(2'd0, 8'h00, "R1 mode reset");
        read_check(2'd1, 8'hFF, "R1 period reset");
        read_check(2'd2, 8'h00, "R1 duty reset");

        // R2 register writes while stopped
        bus_write(2'd1, 8'd9);
        bus_write(2'd2, 8'd3);
        read_check(2'd1, 9, "R2 period readback");
        read_check(2'd2, 3, "R2 duty readback");
        read_check(2'd3, 0, "R2 spare address");
        bus_write(2'd0, 8'h80);
        read_check(2'd0, 8'h80, "R2 mode readback");

        // R3 R4 main waveform N=9 M=3
        expect_run(10, 4, 3, "R3 R4 N=9 M=3");

        // R6 R7 protection while running
        bus_write(2'd1, 8'd50);
        read_check(2'd1, 9, "R6 period locked");
        bus_write(2'd0, 8'h83);
        read_check(2'd0, 8'h80, "R7 select locked");
        expect_run(10, 4, 2, "R6 R7 waveform unchanged");

        // R8 delayed duty transfer
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'd20);
        bus_write(2'd2, 8'd3);
        bus_write(2'd0, 8'h80);
        expect_run(21, 4, 2, "R3 N=20 M=3");
        wait_irq();
        push(21, 4, "R8 period of write uses old duty");
        push(21, 3, "R8 new duty active");
        push(21, 3, "R8 new duty steady");
        bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'd2;
        @(negedge clk); #1;
        bus_wr = 1'b0;
        drain();

        // R10 stop
        bus_write(2'd0, 8'h00);
        begin
            bit quiet = 1'b1;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (pwm_o || irq_o) quiet = 1'b0;
            end
            check(quiet, "R10 output low and no pulse while stopped", int'(quiet), 1);
        end

        // R9 restart without duty rewrite
        bus_write(2'd0, 8'h80);
        check(stale_o == 1'b1, "R9 stale flag set", int'(stale_o), 1);
        expect_run(21, 0, 2, "R9 stale periods low");
        bus_write(2'd2, 8'd5);
        expect_run(21, 6, 2, "R9 R8 stale cleared by transfer");
        check(stale_o == 1'b0, "R9 stale flag cleared", int'(stale_o), 0);

        // R9 rewrite with the same value before start
        bus_write(2'd0, 8'h00);
        bus_write(2'd2, 8'd5);
        bus_write(2'd0, 8'h80);
        check(stale_o == 1'b0, "R9 rewrite avoids stale", int'(stale_o), 0);
        expect_run(21, 6, 1, "R9 same value rewrite");

        // R5 clock select k=2
        bus_write(2'd0, 8'h00);
        bus_write(2'd0, 8'h02);
        bus_write(2'd2, 8'd5);
        bus_write(2'd0, 8'h82);
        read_check(2'd0, 8'h82, "R5 mode with select");
        expect_run(84, 24, 2, "R5 divide by 4");

        // R11 boundaries
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'hFF);
        bus_write(2'd2, 8'hFE);
        bus_write(2'd0, 8'h80);
        expect_run(256, 255, 1, "R11 N=FF M=FE");
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'h01);
        bus_write(2'd2, 8'h00);
        bus_write(2'd0, 8'h80);
        expect_run(2, 1, 3, "R11 N=1 M=0");

        done = 1'b1;
        report();
        $finish;
    end
endmodule